// File: doc/BRIEF.md
# Programmable Clock Divider with Pad Output

This block produces one generated clock from a bank of source clocks. A five-bit selector chooses which source feeds the divider. The divider has two modes. The linear mode divides by an integer value. The exponential mode divides by a power of two that the same value sets. For odd ratios an optional correction stretches the high phase by half a source period, which gives an exact 50/50 duty cycle.

The generator runs only while it is enabled. It also needs a consumer: either the pad path, or a peripheral that asserts its clock request. A pad path copies the generated clock to an output pin and holds a programmable idle level whenever it is not copying. In standby the pad keeps toggling only when the stay-awake option is set. The configuration is treated as static while the generator is enabled; change it only while the enable is low.

Top module: `gclk_gen`

## Requirements
- R1: With `div_pow`=0 the output period is `div_val` source cycles. A `div_val` of 0 or 1 gates the source straight through: the output follows the source while running, and the running state is sampled on falling source edges.
- R2: With `div_pow`=1 the output period is 2^(`div_val`+1) source cycles. The exponent saturates at 17, so every `div_val` of 16 or more divides by 131072.
- R3: For a ratio N>1 the output is high for the first floor(N/2) source cycles of each period, counted from the first running rising edge. With `duty_fix`=1 and N odd, the high phase is extended by half a source cycle. Even ratios do not depend on `duty_fix`.
- R4: While the generator is not running, `gclk` is low and the phase count restarts. The first rising source edge after running starts begins a new period with its high phase.
- R5: The generator runs when `gen_en`=1 and either `periph_req`=1, or `out_en`=1 together with (`standby`=0 or `stby_run`=1).
- R6: `src_sel` codes 0 to 7 choose `src_clk[code]`. Codes 8 to 31 select a constant-low source, so `gclk` stays low.
- R7: `pad_oe` is 1 exactly when `out_en`=1 and `src_sel` is not 1 (code 1 is the pad's own input).
- R8: `pad_out` equals `gclk` when `gen_en`=1, `out_en`=1, `src_sel` is a valid code other than 1, and standby does not block the pad. Otherwise it equals `off_level`.
- R9: In standby with `stby_run`=0, the pad shows `off_level`. The generator still runs if `periph_req`=1. With `stby_run`=1 the pad keeps following `gclk`.
- R10: While `rst_n` is low, all divider state is cleared. Reset release takes effect on the second rising edge of the selected source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| src_clk | input | 8 | Source clock bank |
| src_sel | input | 5 | Source code; 1 is the pad input, 8 and above are reserved |
| div_val | input | 16 | Division value |
| gen_en | input | 1 | Generator enable |
| div_pow | input | 1 | 0 linear divide, 1 power-of-two divide |
| duty_fix | input | 1 | 50/50 correction for odd ratios |
| out_en | input | 1 | Pad output enable |
| off_level | input | 1 | Pad level when not driving the clock |
| stby_run | input | 1 | Keep pad clock running in standby |
| standby | input | 1 | Standby indication |
| periph_req | input | 1 | Peripheral clock request |
| gclk | output | 1 | Generated clock |
| pad_out | output | 1 | Pad output value |
| pad_oe | output | 1 | Pad driver enable |

## Verification
A wrong phase count or a wrong high-phase register shows up at `gclk` within one source half-cycle. It appears as a period of the wrong length or as a high phase off by whole cycles. A fault in the falling-edge stretch register shows only for odd ratios with correction, as a high phase off by half a cycle at the next low-phase sample. A fault in the run decision or the pad gating reaches `gclk` or `pad_out` at the next rising source edge, or at once for the pad level. The bench samples `gclk` and `pad_out` in the middle of every source half-cycle, so any of these faults is caught in the half-cycle where it first appears.

// File: rtl/gclk_pkg.sv
`timescale 1ns/1ps
package gclk_pkg;

  typedef struct packed {
    logic en;
    logic pow;
    logic fix;
    logic oe;
    logic off;
    logic stby_run;
  } gclk_cfg_t;

  // generator needs an enable and a consumer: a peripheral or the pad path
  function automatic logic run_request(gclk_cfg_t c, logic valid, logic stby, logic req);
    return c.en & valid & (req | (c.oe & (~stby | c.stby_run)));
  endfunction

  // pad copies the clock only when allowed to drive and not blocked by standby
  function automatic logic pad_active(gclk_cfg_t c, logic valid, logic self_src, logic stby);
    return c.en & c.oe & valid & ~self_src & (~stby | c.stby_run);
  endfunction

endpackage

// File: rtl/gclk_src_mux.sv
`timescale 1ns/1ps
module gclk_src_mux #(
  parameter int NUM_SRC = 8,
  parameter int SEL_W   = 5
) (
  input  logic [NUM_SRC-1:0] src_clk,
  input  logic [SEL_W-1:0]   sel,
  output logic               sel_clk,
  output logic               sel_valid
);

  always_comb begin
    sel_clk   = 1'b0;
    sel_valid = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (sel == SEL_W'(i)) begin
        sel_clk   = src_clk[i];
        sel_valid = 1'b1;
      end
    end
  end

endmodule

// File: rtl/gclk_ratio.sv
`timescale 1ns/1ps
module gclk_ratio #(
  parameter int DIV_W   = 16,
  parameter int POW_MAX = 17,
  parameter int CNT_W   = 18
) (
  input  logic             pow_mode,
  input  logic [DIV_W-1:0] div,
  output logic [CNT_W-1:0] ratio,
  output logic [CNT_W-1:0] half,
  output logic             odd,
  output logic             bypass
);

  localparam int EXP_W = DIV_W + 1;

  logic [EXP_W-1:0] exp_raw;
  logic [EXP_W-1:0] exp_sat;
  logic [CNT_W-1:0] lin_ratio;
  logic [CNT_W-1:0] pow_ratio;

  always_comb begin
    exp_raw = {1'b0, div} + EXP_W'(1);
    if (exp_raw > EXP_W'(POW_MAX)) begin
      exp_sat = EXP_W'(POW_MAX);
    end else begin
      exp_sat = exp_raw;
    end
    pow_ratio = CNT_W'(1) << exp_sat;
    if (div < DIV_W'(2)) begin
      lin_ratio = CNT_W'(1);
    end else begin
      lin_ratio = CNT_W'(div);
    end
    ratio  = pow_mode ? pow_ratio : lin_ratio;
    half   = ratio >> 1;
    odd    = ratio[0];
    bypass = (ratio == CNT_W'(1));
  end

endmodule

// File: rtl/gclk_divider.sv
`timescale 1ns/1ps
module gclk_divider #(
  parameter int CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] ratio,
  input  logic [CNT_W-1:0] half,
  input  logic             bypass,
  input  logic             stretch,
  output logic             gclk
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             hi_q, hi_d;
  logic             hi_neg_q;
  logic             run_neg_q;

  // next state: phase count and high-phase decision on rising edges
  always_comb begin
    cnt_d = cnt_q;
    hi_d  = hi_q;
    if (!run) begin
      cnt_d = '0;
      hi_d  = 1'b0;
    end else begin
      hi_d = (cnt_q < half);
      if (cnt_q >= ratio - CNT_W'(1)) begin
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      hi_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      hi_q  <= hi_d;
    end
  end

  // falling-edge copies: half-cycle stretch and bypass gate
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_neg_q  <= 1'b0;
      run_neg_q <= 1'b0;
    end else begin
      hi_neg_q  <= hi_q;
      run_neg_q <= run;
    end
  end

  assign gclk = bypass ? (clk & run_neg_q) : (hi_q | (stretch & hi_neg_q));

  a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < ratio));

  a_r1_period_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !bypass && cnt_q == ratio - CNT_W'(1)) |=> (cnt_q == '0));

  a_r4_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0 && !hi_q));

endmodule

// File: rtl/gclk_pad.sv
`timescale 1ns/1ps
module gclk_pad
  import gclk_pkg::*;
#(
  parameter int SEL_W   = 5,
  parameter int PAD_SRC = 1
) (
  input  gclk_cfg_t        cfg,
  input  logic [SEL_W-1:0] sel,
  input  logic             sel_valid,
  input  logic             standby,
  input  logic             gclk,
  output logic             pad_out,
  output logic             pad_oe
);

  logic self_src;
  logic active;

  always_comb begin
    self_src = (sel == SEL_W'(PAD_SRC));
    active   = pad_active(cfg, sel_valid, self_src, standby);
    pad_oe   = cfg.oe & ~self_src;
    pad_out  = active ? gclk : cfg.off;
  end

  always_comb begin
    if (!cfg.oe) begin
      a_r8_idle_level: assert (pad_out == cfg.off);
    end
    if (standby && !cfg.stby_run) begin
      a_r9_standby_idle: assert (pad_out == cfg.off);
    end
  end

endmodule

// File: rtl/gclk_gen.sv
`timescale 1ns/1ps
module gclk_gen
  import gclk_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int SEL_W   = 5,
  parameter int DIV_W   = 16,
  parameter int POW_MAX = 17,
  parameter int PAD_SRC = 1
) (
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_clk,
  input  logic [SEL_W-1:0]   src_sel,
  input  logic [DIV_W-1:0]   div_val,
  input  logic               gen_en,
  input  logic               div_pow,
  input  logic               duty_fix,
  input  logic               out_en,
  input  logic               off_level,
  input  logic               stby_run,
  input  logic               standby,
  input  logic               periph_req,
  output logic               gclk,
  output logic               pad_out,
  output logic               pad_oe
);

  localparam int CNT_W = (POW_MAX + 1 > DIV_W) ? POW_MAX + 1 : DIV_W;

  gclk_cfg_t        cfg;
  logic             sel_clk;
  logic             sel_valid;
  logic [1:0]       rst_pipe;
  logic             div_rst_n;
  logic             run;
  logic [CNT_W-1:0] ratio;
  logic [CNT_W-1:0] half;
  logic             odd;
  logic             bypass;
  logic             stretch;

  assign cfg = '{en: gen_en, pow: div_pow, fix: duty_fix, oe: out_en,
                 off: off_level, stby_run: stby_run};

  gclk_src_mux #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_mux (
    .src_clk  (src_clk),
    .sel      (src_sel),
    .sel_clk  (sel_clk),
    .sel_valid(sel_valid)
  );

  // reset asserted at once, released on the selected source
  always_ff @(posedge sel_clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign div_rst_n = rst_pipe[1];

  gclk_ratio #(.DIV_W(DIV_W), .POW_MAX(POW_MAX), .CNT_W(CNT_W)) u_ratio (
    .pow_mode(cfg.pow),
    .div     (div_val),
    .ratio   (ratio),
    .half    (half),
    .odd     (odd),
    .bypass  (bypass)
  );

  assign run     = run_request(cfg, sel_valid, standby, periph_req);
  assign stretch = cfg.fix & odd & ~bypass;

  gclk_divider #(.CNT_W(CNT_W)) u_div (
    .clk    (sel_clk),
    .rst_n  (div_rst_n),
    .run    (run),
    .ratio  (ratio),
    .half   (half),
    .bypass (bypass),
    .stretch(stretch),
    .gclk   (gclk)
  );

  gclk_pad #(.SEL_W(SEL_W), .PAD_SRC(PAD_SRC)) u_pad (
    .cfg      (cfg),
    .sel      (src_sel),
    .sel_valid(sel_valid),
    .standby  (standby),
    .gclk     (gclk),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe)
  );

endmodule

// File: tb/tb_gclk_gen.sv
`timescale 1ns/1ps
module tb_gclk_gen;

  logic        rst_n;
  logic [7:0]  sclk;
  logic [4:0]  sel;
  logic [15:0] div;
  logic gen_en, divp, dfix, oe, oov, srun, stby, preq;
  logic gclk, pad_out, pad_oe;
  logic bsrc;

  int    n_checks = 0;
  int    n_err = 0;
  bit    done = 0;
  string cur_req = "R10";

  // model state
  int k = 0;
  bit mq = 0, mqn = 0, mrn = 0;
  int rs_cnt = 0;

  for (genvar g = 0; g < 8; g++) begin : g_clk
    logic c;
    initial begin
      c = 1'b0;
      forever #(2.5 + 0.5 * g) c = ~c;
    end
    assign sclk[g] = c;
  end

  always_comb bsrc = (sel < 5'd8) ? sclk[sel[2:0]] : 1'b0;

  gclk_gen dut (
    .rst_n(rst_n), .src_clk(sclk), .src_sel(sel), .div_val(div),
    .gen_en(gen_en), .div_pow(divp), .duty_fix(dfix), .out_en(oe),
    .off_level(oov), .stby_run(srun), .standby(stby), .periph_req(preq),
    .gclk(gclk), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  function automatic int ratio_f();
    int e;
    if (!divp) return (div < 2) ? 1 : int'(div);
    e = int'(div) + 1;
    if (e > 17) e = 17;
    return 1 << e;
  endfunction

  function automatic bit run_f();
    return gen_en && sel < 8 && (preq || (oe && (!stby || srun)));
  endfunction

  function automatic bit exp_gclk(bit high_phase);
    int n;
    n = ratio_f();
    if (n == 1) return high_phase && mrn;
    return mq || (dfix && (n % 2 == 1) && mqn);
  endfunction

  function automatic real half_per();
    return 2.5 + 0.5 * real'(sel);
  endfunction

  task automatic check(bit eg);
    bit act, epo, epe;
    act = gen_en && oe && sel < 8 && sel != 5'd1 && (!stby || srun);
    epe = oe && sel != 5'd1;
    epo = act ? eg : oov;
    n_checks++;
    if (gclk !== eg || pad_out !== epo || pad_oe !== epe) begin
      n_err++;
      $display("FAIL %s t=%0t gclk/pad_out/pad_oe actual %b%b%b expected %b%b%b",
               cur_req, $time, gclk, pad_out, pad_oe, eg, epo, epe);
    end
  endtask

  always @(posedge bsrc) begin
    int n;
    real hp;
    hp = half_per();
    n = ratio_f();
    if (rs_cnt >= 2 && run_f()) begin
      mq = (k % n) < (n / 2);
      k = (k + 1) % n;
    end else begin
      mq = 0;
      k = 0;
    end
    rs_cnt = rst_n ? ((rs_cnt < 2) ? rs_cnt + 1 : 2) : 0;
    #(hp / 2.0);
    if (rst_n && !done) check(exp_gclk(1'b1));
  end

  always @(negedge bsrc) begin
    real hp;
    hp = half_per();
    if (rs_cnt >= 2) begin
      mqn = mq;
      mrn = run_f();
    end else begin
      mqn = 0;
      mrn = 0;
    end
    #(hp / 2.0);
    if (rst_n && !done) check(exp_gclk(1'b0));
  end

  task automatic cyc(int n);
    repeat (n) @(negedge bsrc);
    #0.5;
  endtask

  task automatic setup(input string req, input logic [4:0] s, input logic [15:0] d,
                       input logic p, input logic f, input logic o, input logic v);
    gen_en = 0;
    cyc(3);
    cur_req = req;
    sel = s; div = d; divp = p; dfix = f; oe = o; oov = v;
    #20;
    cyc(2);
    gen_en = 1;
  endtask

  initial begin
    #100000;
    n_err++;
    $display("FAIL R10 watchdog: actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    rst_n = 0; sel = 0; div = 0; gen_en = 0; divp = 0; dfix = 0;
    oe = 0; oov = 0; srun = 0; stby = 0; preq = 0;
    #12;
    cur_req = "R10"; // reset state
    check(1'b0);
    #1 rst_n = 1;
    cyc(10);

    setup("R1", 5'd0, 16'd0, 0, 0, 1, 0); cyc(12);   // R1 bypass, pad copies
    setup("R1", 5'd0, 16'd1, 0, 0, 0, 0); cyc(12);
    setup("R1", 5'd0, 16'd4, 0, 1, 1, 0); cyc(16);   // even ratio ignores fix
    setup("R3", 5'd0, 16'd5, 0, 0, 1, 0); cyc(20);   // odd, no correction
    setup("R3", 5'd0, 16'd5, 0, 1, 1, 0); cyc(20);   // odd, corrected
    setup("R6", 5'd3, 16'd3, 0, 1, 1, 1); cyc(15);   // other source
    setup("R8", 5'd6, 16'd7, 0, 1, 1, 0); cyc(20);
    setup("R2", 5'd0, 16'd0, 1, 0, 1, 0); cyc(10);   // divide by 2
    setup("R2", 5'd0, 16'd2, 1, 0, 1, 0); cyc(24);   // divide by 8
    setup("R2", 5'd0, 16'd20, 1, 0, 1, 0); cyc(40);  // saturates at 2^17

    setup("R4", 5'd0, 16'd3, 0, 0, 1, 0); cyc(4);    // restart mid period
    gen_en = 0; cyc(3);
    gen_en = 1; cyc(9);

    setup("R5", 5'd0, 16'd2, 0, 0, 0, 1);            // pad disabled, request driven
    preq = 0; cyc(8);
    preq = 1; cyc(12);
    preq = 0; cyc(6);

    setup("R9", 5'd0, 16'd2, 0, 0, 1, 1);
    stby = 1; srun = 0; preq = 0; cyc(8);            // stopped, pad idle
    preq = 1; cyc(8);                                // runs for peripheral only
    preq = 0; srun = 1; cyc(10);                     // pad kept running
    stby = 0; srun = 0;

    setup("R7", 5'd1, 16'd2, 0, 0, 1, 1); cyc(12);   // pad is its own source

    gen_en = 0; cyc(3);
    cur_req = "R6"; // reserved code: constant-low source
    sel = 5'd9; oe = 1; oov = 1; gen_en = 1;
    repeat (6) begin
      #7;
      check(1'b0);
    end
    gen_en = 0; sel = 5'd0; oov = 0;
    #20;
    cyc(4);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

endmodule